// File: doc/BRIEF.md
# Paged SRAM Write Guard

This block sits on the write path of an on-chip SRAM that is divided into pages of 1 kB. Software marks pages read-only by setting bits in two 32-bit protection registers, one bit per page, for up to 64 pages. Every bus write is decoded to its page. If the bit for that page is set, the memory write enable is withheld in the same cycle and a fault pulse is sent toward the bus-error or hard-fault logic.

Protection bits can only be set. Writing zeros to a register changes nothing, and only a reset returns a bit to zero. Writes issued by the internal mass-erase engine carry a bypass flag, so they reach protected pages as well. The number of implemented pages is a parameter. Bits for pages that do not exist read as zero and can never be set.

Top module: `page_write_guard`

## Requirements
- R1: After reset, both protection registers read zero and `wrFault` is low.
- R2: A register write ORs `regWrData` into the selected register. A 1 sets a bit, a 0 leaves it unchanged, and no register write can clear a bit.
- R3: `regWrSel`/`regRdSel` = 0 selects the register for pages 0 to 31, where bit n is page n. A value of 1 selects the register for pages 32 to 63, where bit n is page 32+n. `regRdData` shows the selected register in the same cycle.
- R4: The page index is byte-offset bits [15:10] of `busWrAddr`. Bits [9:0] have no influence on the decision.
- R5: A bus write (`busWrValid`=1, `busWrErase`=0) to a page whose bit is set sees `memWrEn`=0 in that same cycle.
- R6: Each blocked write produces `wrFault`=1 for exactly the one following cycle. Back-to-back blocked writes give back-to-back pulses. `wrFault` is never high without a blocked write in the previous cycle.
- R7: A bus write to an unprotected page drives `memWrEn`=1 in the same cycle and raises no fault. With `busWrValid`=0, `memWrEn` stays 0.
- R8: A write with `busWrErase`=1 drives `memWrEn`=1 and raises no fault, even when its page is protected.
- R9: Bits for page indices at or above `NUM_PAGES` read as zero, ignore writes of 1, and never block a write.
- R10: A protection bit set by a register write acts from the next cycle on. A bus write to that page in the same cycle as the register write still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Protection register write strobe |
| regWrSel | input | 1 | Register chosen for writing (0: pages 0-31, 1: pages 32-63) |
| regWrData | input | 32 | Bits to set in the chosen register |
| regRdSel | input | 1 | Register chosen for reading |
| regRdData | output | 32 | Contents of the register chosen for reading |
| busWrValid | input | 1 | A bus write to the SRAM is presented |
| busWrAddr | input | PAGE_SHIFT+6 | Byte offset of the write into the SRAM |
| busWrErase | input | 1 | Write comes from the mass-erase engine and bypasses protection |
| memWrEn | output | 1 | Write enable passed on to the memory array |
| wrFault | output | 1 | One-cycle pulse after a blocked write |

## Verification
A lost or wrongly set protection bit reaches the ports in two ways. It is visible on `regRdData` in the cycle it changes, and it alters `memWrEn` on the first write to that page. A wrong page decode shows up on `memWrEn` as soon as a write lands on a page whose protection differs from the page intended. A fault register that is late, sticky or missing differs from the expected pulse one cycle after the blocked write. The bench's model predicts all three outputs on every cycle, so any such mismatch is reported in the cycle it first appears.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_REGS  = 2;
  localparam int MAX_PAGES = REG_W * NUM_REGS;
  localparam int IDX_W     = $clog2(MAX_PAGES);

  // strobes from control to datapath and top
  typedef struct packed {
    logic setLo;
    logic setHi;
    logic grant;
    logic block;
  } pwg_strobe_t;
endpackage

// File: rtl/pwg_datapath.sv
module pwg_datapath
  import pwg_pkg::*;
#(
  parameter int NUM_PAGES  = 64,
  parameter int PAGE_SHIFT = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pwg_strobe_t                 strobes,
  input  logic [REG_W-1:0]            regWrData,
  input  logic                        regRdSel,
  input  logic [PAGE_SHIFT+IDX_W-1:0] busWrAddr,
  output logic [REG_W-1:0]            regRdData,
  output logic [MAX_PAGES-1:0]        protVec,
  output logic                        pageProt
);
  localparam logic [MAX_PAGES-1:0] IMPL_MASK = {MAX_PAGES{1'b1}} >> (MAX_PAGES - NUM_PAGES);

  logic [REG_W-1:0] protReg [NUM_REGS];
  logic [NUM_REGS-1:0] setReg;
  logic [IDX_W-1:0] pageIdx;

  assign setReg = {strobes.setHi, strobes.setLo};

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        protReg[g] <= '0;
      end else if (setReg[g]) begin
        protReg[g] <= protReg[g] | (regWrData & IMPL_MASK[g*REG_W +: REG_W]);
      end
    end
    assign protVec[g*REG_W +: REG_W] = protReg[g];
  end

  assign regRdData = protReg[regRdSel];
  assign pageIdx   = busWrAddr[PAGE_SHIFT +: IDX_W];
  assign pageProt  = protVec[pageIdx];
endmodule

// File: rtl/pwg_ctrl.sv
module pwg_ctrl
  import pwg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic        busWrValid,
  input  logic        busWrErase,
  input  logic        pageProt,
  output pwg_strobe_t strobes,
  output logic        wrFault
);
  always_comb begin
    strobes.setLo = regWrEn & ~regWrSel;
    strobes.setHi = regWrEn & regWrSel;
    strobes.grant = busWrValid & (busWrErase | ~pageProt);
    strobes.block = busWrValid & ~busWrErase & pageProt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrFault <= 1'b0;
    else       wrFault <= strobes.block;
  end
endmodule

// File: rtl/page_write_guard.sv
module page_write_guard
  import pwg_pkg::*;
#(
  parameter int NUM_PAGES  = 64,
  parameter int PAGE_SHIFT = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic                        regWrSel,
  input  logic [31:0]                 regWrData,
  input  logic                        regRdSel,
  output logic [31:0]                 regRdData,
  input  logic                        busWrValid,
  input  logic [PAGE_SHIFT+IDX_W-1:0] busWrAddr,
  input  logic                        busWrErase,
  output logic                        memWrEn,
  output logic                        wrFault
);
  pwg_strobe_t strobes;
  logic [MAX_PAGES-1:0] protVec;
  logic pageProt;

  pwg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .busWrValid(busWrValid), .busWrErase(busWrErase), .pageProt(pageProt),
    .strobes(strobes), .wrFault(wrFault)
  );

  pwg_datapath #(.NUM_PAGES(NUM_PAGES), .PAGE_SHIFT(PAGE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .regRdSel(regRdSel), .busWrAddr(busWrAddr), .regRdData(regRdData),
    .protVec(protVec), .pageProt(pageProt)
  );

  assign memWrEn = strobes.grant;
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker
  import pwg_pkg::*;
#(
  parameter int NUM_PAGES = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [MAX_PAGES-1:0] protVec,
  input logic                 busWrValid,
  input logic                 busWrErase,
  input logic                 memWrEn,
  input logic                 wrFault
);
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (protVec & $past(protVec)) == $past(protVec)); // R2
  AST_BLOCK_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrValid && !busWrErase && !memWrEn) |=> wrFault); // R6
  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> $past(busWrValid && !busWrErase && !memWrEn)); // R6
  AST_ERASE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrValid && busWrErase) |-> memWrEn); // R8
  AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rstN)
    !busWrValid |-> !memWrEn); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (protVec >> NUM_PAGES) == '0); // R9
endmodule

bind page_write_guard pwg_checker #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk(clk), .rstN(rstN), .protVec(protVec), .busWrValid(busWrValid),
  .busWrErase(busWrErase), .memWrEn(memWrEn), .wrFault(wrFault)
);

// File: tb/page_write_guard_bench.sv
module page_write_guard_bench;
  localparam int NP = 48;
  localparam int PS = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regWrSel = 1'b0, regRdSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic busWrValid = 1'b0, busWrErase = 1'b0;
  logic [15:0] busWrAddr = '0;
  logic memWrEn, wrFault;

  int nTests = 0;
  int nFail = 0;

  // reference state
  bit [63:0] mProt = '0;
  bit mFault = 1'b0;

  always #2 clk = ~clk;

  page_write_guard #(.NUM_PAGES(NP), .PAGE_SHIFT(PS)) u_page_write_guard (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .busWrValid(busWrValid), .busWrAddr(busWrAddr), .busWrErase(busWrErase),
    .memWrEn(memWrEn), .wrFault(wrFault)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit modelProt(input logic [15:0] a);
    int page;
    page = int'(a) >> PS;
    return (page < NP) ? mProt[page] : 1'b0;
  endfunction

  // one cycle: drive at negedge, compare before the edge, advance model after it
  task automatic cyc(input bit we, input bit ws, input logic [31:0] wd, input bit rs,
                     input bit v, input logic [15:0] a, input bit er);
    bit expEn, blk;
    logic [31:0] expRd;
    @(negedge clk);
    regWrEn = we; regWrSel = ws; regWrData = wd; regRdSel = rs;
    busWrValid = v; busWrAddr = a; busWrErase = er;
    #1;
    // R5 R7 R8 R9 R10 R4: enable decided from protection state before this edge
    expEn = v && (er || !modelProt(a));
    blk = v && !er && modelProt(a);
    check(er ? "R8" : (blk ? "R5" : "R7"), longint'(memWrEn), longint'(expEn));
    check("R6", longint'(wrFault), longint'(mFault));
    expRd = rs ? mProt[63:32] : mProt[31:0];
    check("R3", longint'(regRdData), longint'(expRd));
    @(posedge clk);
    #0;
    if (we) begin
      if (ws) mProt[63:32] = mProt[63:32] | wd;
      else    mProt[31:0]  = mProt[31:0] | wd;
      mProt = mProt & ((64'h1 << NP) - 64'h1);
    end
    mFault = blk;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    regWrEn = 0; busWrValid = 0; busWrErase = 0;
    @(negedge clk);
    mProt = '0; mFault = 0;
    rstN = 1'b1;
    #1;
    // R1: cleared state
    regRdSel = 0; #1;
    check("R1", longint'(regRdData), 0);
    check("R1", longint'(wrFault), 0);
    regRdSel = 1; #1;
    check("R1", longint'(regRdData), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    doReset();
    cyc(0, 0, 0, 0, 1, 16'h1400, 0);                 // R7 page 5 open
    // R10: set pages 0 and 5 while writing page 5 in the same cycle
    cyc(1, 0, 32'h21, 0, 1, 16'h1400, 0);
    cyc(0, 0, 0, 0, 1, 16'h17FF, 0);                 // R5 R4 last byte of page 5
    cyc(0, 0, 0, 0, 1, 16'h1803, 0);                 // R4 page 6 open, R6 pulse
    cyc(0, 0, 0, 0, 0, 16'h0000, 0);                 // R6 pulse ends
    cyc(1, 0, 32'h0, 0, 0, 0, 0);                    // R2 zero write changes nothing
    cyc(0, 0, 0, 0, 1, 16'h0000, 0);                 // R2 page 0 still protected
    // R9: upper bits of high register ignored
    cyc(1, 1, 32'hFFFF_0003, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 16'h8400, 0);                 // R3 page 33 blocked
    cyc(0, 0, 0, 1, 1, 16'hC800, 0);                 // R9 page 50 never blocked
    cyc(1, 1, 32'hFFFF_FFFF, 1, 1, 16'hFC00, 0);     // R9 page 63
    cyc(0, 0, 0, 1, 1, 16'hFC00, 0);                 // R9
    cyc(0, 0, 0, 0, 1, 16'h0010, 1);                 // R8 erase bypass
    cyc(0, 0, 0, 0, 1, 16'h0000, 0);                 // R6 back-to-back
    cyc(0, 0, 0, 0, 1, 16'h8000, 0);
    cyc(0, 0, 0, 0, 0, 16'h0000, 0);
    doReset();                                       // R1 clears set bits
    cyc(0, 0, 0, 0, 1, 16'h0000, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rw;
      rw = $urandom() & $urandom() & $urandom();
      cyc(($urandom() % 6) == 0, $urandom() % 2, rw, $urandom() % 2,
          $urandom() % 2, 16'($urandom()), ($urandom() % 8) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule